// File: doc/BRIEF.md
# Banked Working Register File with Context Switching

This block holds the sixteen 16-bit working registers of a processor core. Registers 0 to 14 exist in three copies, called contexts: context 0 is the default set, and contexts 1 and 2 are alternate sets. Register 15 is the software stack pointer. It exists once and is seen from every context. Any register may serve as a data value, an address or an address offset. Two combinational read ports and one write port always address the context that is active at the time.

The active context changes in two ways. The first is automatic. Each alternate set carries a 3-bit field that binds it to one interrupt priority level from 1 to 6. On interrupt entry at a bound level, that set becomes active, and the context it replaces is pushed onto a 7-deep internal context stack. On interrupt return, the context on top of the stack is restored. The second is a manual swap request, with which software selects a context directly. An alternate set keeps its contents while it is inactive, so an interrupt handler finds its registers as it left them and has nothing to save or restore.

The decoder, the interrupt controller and the stack-pointer push/pop logic are outside this block. They supply the priority level, the entry and return strobes, and the swap requests.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted, the block selects context 0. It clears every register in every context, clears both status outputs and empties the context stack. After reset, every read returns 0.
- R2: A write with `wr_en` high stores `wr_data` at the rising clock edge into register `wr_idx` of the active context. Both read ports return the addressed register of the active context combinationally.
- R3: Index 15 addresses one shared register. A value written to it is read back unchanged from every context.
- R4: Each context keeps its registers 0 to 14 while it is inactive. Switching away and back returns the values last written in that context.
- R5: `alt_ipl_cfg[2:0]` binds context 1 and `alt_ipl_cfg[5:3]` binds context 2. On `irq_enter`, if a field equals `irq_level` and lies in 1 to 6, its context becomes active on the next cycle and the prior context is pushed. If both fields match, context 1 wins.
- R6: On `irq_enter` at a level that no field binds, or when a field value is 0 or 7, the current context is pushed but stays active.
- R7: `irq_return` makes the context on top of the stack active on the next cycle and pops it. A return with an empty stack is ignored.
- R8: The stack holds 7 contexts. An `irq_enter` while 7 are held is ignored entirely: there is no push and no switch.
- R9: A `swap_req` with `swap_ctx` of 0, 1 or 2 makes that context active on the next cycle and sets `last_manual_ctx` to it. A `swap_ctx` above 2 leaves both `cur_ctx` and `last_manual_ctx` unchanged.
- R10: Events in the same cycle are resolved in this order: `irq_enter` first, then `irq_return`, then `swap_req`. A swap that loses does not update `last_manual_ctx`.
- R11: A write in the same cycle as any context switch lands in the context that was active before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 16 | Write data |
| alt_ipl_cfg | input | 6 | Priority binding fields for contexts 1 and 2 |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_level | input | 3 | Priority level of the entering interrupt |
| irq_return | input | 1 | Interrupt return strobe |
| swap_req | input | 1 | Manual context swap strobe |
| swap_ctx | input | 3 | Target context of a manual swap |
| cur_ctx | output | 3 | Active context number |
| last_manual_ctx | output | 3 | Context most recently chosen by a valid swap |

## Verification
Two kinds of same-cycle collision are tested.

The first is a register write in the same cycle as a context switch. The bench writes a register in the same cycle as a manual swap. It then reads that register from both contexts: the new context must still show its old value, and the old context must show the written value.

The second is two control strobes in the same cycle. The vector table pairs an interrupt entry with a swap, a return with a swap, and an entry with a return. After each pair, the bench compares the active context and the last-manual field with the outcome the priority order predicts.

// File: rtl/bregs_pkg.sv
package bregs_pkg;
  localparam int CTX_W   = 3;
  localparam int IPL_W   = 3;
  localparam int MAX_IPL = 6;
  typedef logic [CTX_W-1:0] ctx_t;
endpackage

// File: rtl/ctx_match.sv
module ctx_match
  import bregs_pkg::*;
#(
  parameter int NUM_ALT = 2
) (
  input  logic [NUM_ALT*IPL_W-1:0] cfg,
  input  logic [IPL_W-1:0]         level,
  output logic                     hit,
  output ctx_t                     sel
);
  // Scan from the highest set down so that the lowest-numbered match wins.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int k = NUM_ALT; k >= 1; k--) begin
      if (cfg[(k-1)*IPL_W +: IPL_W] != '0 &&
          cfg[(k-1)*IPL_W +: IPL_W] <= IPL_W'(MAX_IPL) &&
          cfg[(k-1)*IPL_W +: IPL_W] == level) begin
        hit = 1'b1;
        sel = CTX_W'(k);
      end
    end
  end
endmodule

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import bregs_pkg::*;
#(
  parameter int NUM_ALT   = 2,
  parameter int STK_DEPTH = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_ALT*IPL_W-1:0] alt_ipl_cfg,
  input  logic                     irq_enter,
  input  logic [IPL_W-1:0]         irq_level,
  input  logic                     irq_return,
  input  logic                     swap_req,
  input  ctx_t                     swap_ctx,
  output ctx_t                     cur_ctx,
  output ctx_t                     last_manual_ctx
);
  localparam int DEP_W = $clog2(STK_DEPTH + 1);

  ctx_t             cur_q, cur_d;
  ctx_t             last_q, last_d;
  logic [DEP_W-1:0] dep_q, dep_d;
  ctx_t             stk_q [STK_DEPTH];
  logic             bind_hit;
  ctx_t             bind_sel;
  logic             do_enter, do_ret, do_swap;
  ctx_t             top_ctx;

  ctx_match #(.NUM_ALT(NUM_ALT)) u_match (
    .cfg  (alt_ipl_cfg),
    .level(irq_level),
    .hit  (bind_hit),
    .sel  (bind_sel)
  );

  assign top_ctx  = (dep_q != '0) ? stk_q[dep_q - DEP_W'(1)] : '0;
  assign do_enter = irq_enter && (dep_q < DEP_W'(STK_DEPTH));
  assign do_ret   = !irq_enter && irq_return && (dep_q != '0);
  assign do_swap  = !irq_enter && !irq_return && swap_req &&
                    (swap_ctx <= CTX_W'(NUM_ALT));

  always_comb begin
    cur_d  = cur_q;
    last_d = last_q;
    dep_d  = dep_q;
    if (do_enter) begin
      dep_d = dep_q + DEP_W'(1);
      if (bind_hit) cur_d = bind_sel;
    end else if (do_ret) begin
      dep_d = dep_q - DEP_W'(1);
      cur_d = top_ctx;
    end else if (do_swap) begin
      cur_d  = swap_ctx;
      last_d = swap_ctx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      last_q <= '0;
      dep_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      last_q <= last_d;
      dep_q  <= dep_d;
    end
  end

  // One register per stack slot, each loaded only when a push targets it.
  for (genvar s = 0; s < STK_DEPTH; s++) begin : g_slot
    logic slot_en;
    assign slot_en = do_enter && (dep_q == DEP_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stk_q[s] <= '0;
      else if (slot_en) stk_q[s] <= cur_q;
    end
  end

  assign cur_ctx         = cur_q;
  assign last_manual_ctx = last_q;

  // R9
  ctx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= CTX_W'(NUM_ALT) && last_q <= CTX_W'(NUM_ALT));
  // R8
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dep_q <= DEP_W'(STK_DEPTH));
  // R9
  bad_swap_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && swap_ctx > CTX_W'(NUM_ALT) && !irq_enter && !irq_return)
      |=> ($stable(cur_q) && $stable(last_q)));
  // R10
  swap_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && (irq_enter || irq_return)) |=> $stable(last_q));
  // R6
  unbound_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !bind_hit) |=> $stable(cur_q));
  // R8
  full_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && dep_q == DEP_W'(STK_DEPTH)) |=> ($stable(cur_q) && $stable(dep_q)));
  // R7
  pop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_enter && dep_q != '0) |=> (cur_q == $past(top_ctx)));
endmodule

// File: rtl/reg_banks.sv
module reg_banks
  import bregs_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_REG = 16,
  parameter int NUM_ALT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctx_t                       act_ctx,
  input  logic                       wr_en,
  input  logic [$clog2(NUM_REG)-1:0] wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [$clog2(NUM_REG)-1:0] rd_a_idx,
  input  logic [$clog2(NUM_REG)-1:0] rd_b_idx,
  output logic [DATA_W-1:0]          rd_a_data,
  output logic [DATA_W-1:0]          rd_b_data
);
  localparam int IDX_W   = $clog2(NUM_REG);
  localparam int NUM_CTX = NUM_ALT + 1;
  localparam int SP_IDX  = NUM_REG - 1;

  logic [DATA_W-1:0] bank_q [NUM_CTX][SP_IDX];
  logic [DATA_W-1:0] sp_q;
  logic              sp_we;

  assign sp_we = wr_en && (wr_idx == IDX_W'(SP_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_we) sp_q <= wr_data;
  end

  for (genvar b = 0; b < NUM_CTX; b++) begin : g_bank
    for (genvar r = 0; r < SP_IDX; r++) begin : g_reg
      logic we;
      assign we = wr_en && (act_ctx == CTX_W'(b)) && (wr_idx == IDX_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bank_q[b][r] <= '0;
        else if (we) bank_q[b][r] <= wr_data;
      end
    end
  end

  function automatic logic [DATA_W-1:0] pick(input logic [IDX_W-1:0] idx,
                                             input ctx_t ctx);
    if (idx == IDX_W'(SP_IDX))        return sp_q;
    else if (ctx > CTX_W'(NUM_ALT))   return '0;
    else                              return bank_q[ctx][idx];
  endfunction

  assign rd_a_data = pick(rd_a_idx, act_ctx);
  assign rd_b_data = pick(rd_b_idx, act_ctx);

  // R3
  sp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |=> (sp_q == $past(wr_data)));
  // R3
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_we |=> $stable(sp_q));
  // R2
  read_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == IDX_W'(SP_IDX)) |-> (rd_a_data == sp_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bregs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_REG   = 16,
  parameter int NUM_ALT   = 2,
  parameter int STK_DEPTH = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NUM_REG)-1:0] rd_a_idx,
  output logic [DATA_W-1:0]          rd_a_data,
  input  logic [$clog2(NUM_REG)-1:0] rd_b_idx,
  output logic [DATA_W-1:0]          rd_b_data,
  input  logic                       wr_en,
  input  logic [$clog2(NUM_REG)-1:0] wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [NUM_ALT*IPL_W-1:0]   alt_ipl_cfg,
  input  logic                       irq_enter,
  input  logic [IPL_W-1:0]           irq_level,
  input  logic                       irq_return,
  input  logic                       swap_req,
  input  logic [CTX_W-1:0]           swap_ctx,
  output logic [CTX_W-1:0]           cur_ctx,
  output logic [CTX_W-1:0]           last_manual_ctx
);
  ctx_t act_ctx;

  ctx_ctrl #(.NUM_ALT(NUM_ALT), .STK_DEPTH(STK_DEPTH)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .alt_ipl_cfg    (alt_ipl_cfg),
    .irq_enter      (irq_enter),
    .irq_level      (irq_level),
    .irq_return     (irq_return),
    .swap_req       (swap_req),
    .swap_ctx       (swap_ctx),
    .cur_ctx        (act_ctx),
    .last_manual_ctx(last_manual_ctx)
  );

  // The bank select is the registered context, so a write in a switching
  // cycle still lands in the bank that was active before the edge.
  reg_banks #(.DATA_W(DATA_W), .NUM_REG(NUM_REG), .NUM_ALT(NUM_ALT)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_ctx  (act_ctx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_a_idx (rd_a_idx),
    .rd_b_idx (rd_b_idx),
    .rd_a_data(rd_a_data),
    .rd_b_data(rd_b_data)
  );

  assign cur_ctx = act_ctx;

  // R11
  switch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '1 && swap_req && swap_ctx != act_ctx &&
     swap_ctx <= CTX_W'(NUM_ALT) && !irq_enter && !irq_return)
      |=> (cur_ctx == $past(swap_ctx)));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [15:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, irq_enter, irq_return, swap_req;
  logic [5:0]  alt_ipl_cfg;
  logic [2:0]  irq_level, swap_ctx, cur_ctx, last_manual_ctx;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .alt_ipl_cfg(alt_ipl_cfg), .irq_enter(irq_enter), .irq_level(irq_level),
    .irq_return(irq_return), .swap_req(swap_req), .swap_ctx(swap_ctx),
    .cur_ctx(cur_ctx), .last_manual_ctx(last_manual_ctx)
  );

  // Vector: {enter, ret, swap, swap_ctx, level, exp_cur, exp_last}
  // Binding for the table: context 1 at level 3, context 2 at level 5.
  localparam logic [14:0] VEC [15] = '{
    {1'b1,1'b0,1'b0,3'd0,3'd3,3'd1,3'd0},  // R5 enter bound -> 1
    {1'b1,1'b0,1'b0,3'd0,3'd5,3'd2,3'd0},  // R5 nested -> 2
    {1'b1,1'b0,1'b0,3'd0,3'd2,3'd2,3'd0},  // R6 unbound stays
    {1'b0,1'b1,1'b0,3'd0,3'd0,3'd2,3'd0},  // R7 pop 2
    {1'b0,1'b1,1'b0,3'd0,3'd0,3'd1,3'd0},  // R7 pop 1
    {1'b0,1'b1,1'b0,3'd0,3'd0,3'd0,3'd0},  // R7 pop 0
    {1'b0,1'b1,1'b0,3'd0,3'd0,3'd0,3'd0},  // R7 empty ignored
    {1'b0,1'b0,1'b1,3'd2,3'd0,3'd2,3'd2},  // R9 swap 2
    {1'b0,1'b0,1'b1,3'd5,3'd0,3'd2,3'd2},  // R9 bad swap ignored
    {1'b0,1'b0,1'b1,3'd1,3'd0,3'd1,3'd1},  // R9 swap 1
    {1'b1,1'b0,1'b1,3'd0,3'd5,3'd2,3'd1},  // R10 enter beats swap
    {1'b0,1'b1,1'b1,3'd0,3'd0,3'd1,3'd1},  // R10 return beats swap
    {1'b1,1'b1,1'b0,3'd0,3'd3,3'd1,3'd1},  // R10 enter beats return
    {1'b0,1'b1,1'b0,3'd0,3'd0,3'd1,3'd1},  // R7 pop 1
    {1'b0,1'b0,1'b1,3'd0,3'd0,3'd0,3'd0}   // R9 swap 0
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    irq_enter = 1'b0; irq_return = 1'b0; swap_req = 1'b0; wr_en = 1'b0;
  endtask

  task automatic enter(input logic [2:0] lvl);
    irq_enter = 1'b1; irq_level = lvl; cyc();
  endtask

  task automatic leave();
    irq_return = 1'b1; cyc();
  endtask

  task automatic swap(input logic [2:0] c);
    swap_req = 1'b1; swap_ctx = c; cyc();
  endtask

  task automatic wr(input logic [3:0] i, input logic [15:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d; cyc();
  endtask

  function automatic logic [15:0] rd(input logic [3:0] i);
    rd_a_idx = i;
    return 16'h0;
  endfunction

  task automatic rd_chk(input string req, input logic [3:0] i, input logic [15:0] exp);
    rd_a_idx = i; rd_b_idx = i; #1;
    chk(req, rd_a_data, exp);
    chk(req, rd_b_data, exp);
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; irq_enter = 0; irq_return = 0; swap_req = 0;
    rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
    irq_level = 0; swap_ctx = 0; alt_ipl_cfg = {3'd5, 3'd3};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 cur", 16'(cur_ctx), 16'd0);
    chk("R1 last", 16'(last_manual_ctx), 16'd0);
    rd_chk("R1 r0", 4'd0, 16'h0);
    rd_chk("R1 r15", 4'd15, 16'h0);

    for (int v = 0; v < 15; v++) begin
      irq_enter  = VEC[v][14];
      irq_return = VEC[v][13];
      swap_req   = VEC[v][12];
      swap_ctx   = VEC[v][11:9];
      irq_level  = VEC[v][8:6];
      cyc();
      chk($sformatf("R5-R10 table cur v%0d", v), 16'(cur_ctx), 16'(VEC[v][5:3]));
      chk($sformatf("R9/R10 table last v%0d", v), 16'(last_manual_ctx), 16'(VEC[v][2:0]));
    end

    // R2 write and read in context 0
    wr(4'd3, 16'h1111);
    wr(4'd15, 16'hF00F);
    rd_a_idx = 4'd3; rd_b_idx = 4'd15; #1;
    chk("R2 port A", rd_a_data, 16'h1111);
    chk("R2 port B", rd_b_data, 16'hF00F);
    // R4 persistence, R3 shared stack pointer
    swap(3'd1);
    rd_chk("R4 fresh ctx1 r3", 4'd3, 16'h0);
    rd_chk("R3 sp in ctx1", 4'd15, 16'hF00F);
    wr(4'd3, 16'h2222);
    swap(3'd2);
    wr(4'd3, 16'h3333);
    rd_chk("R3 sp in ctx2", 4'd15, 16'hF00F);
    swap(3'd0);
    rd_chk("R4 ctx0 r3", 4'd3, 16'h1111);
    swap(3'd1);
    rd_chk("R4 ctx1 r3", 4'd3, 16'h2222);
    swap(3'd2);
    rd_chk("R4 ctx2 r3", 4'd3, 16'h3333);

    // R11 write in a switching cycle goes to the old context
    wr_en = 1'b1; wr_idx = 4'd4; wr_data = 16'hABCD;
    swap_req = 1'b1; swap_ctx = 3'd0;
    cyc();
    chk("R11 cur", 16'(cur_ctx), 16'd0);
    rd_chk("R11 new ctx untouched", 4'd4, 16'h0);
    swap(3'd2);
    rd_chk("R11 old ctx got write", 4'd4, 16'hABCD);
    swap(3'd0);

    // R5 both sets bound to the same level: context 1 wins
    alt_ipl_cfg = {3'd4, 3'd4};
    enter(3'd4);
    chk("R5 tie", 16'(cur_ctx), 16'd1);
    leave();
    chk("R7 back", 16'(cur_ctx), 16'd0);

    // R6 out-of-range binding values
    alt_ipl_cfg = {3'd7, 3'd0};
    enter(3'd7);
    chk("R6 field 7", 16'(cur_ctx), 16'd0);
    enter(3'd0);
    chk("R6 field 0", 16'(cur_ctx), 16'd0);
    leave(); leave();
    alt_ipl_cfg = {3'd5, 3'd3};

    // R8 stack full
    for (int k = 0; k < 6; k++) enter(3'd2);
    enter(3'd3);
    chk("R8 seventh push", 16'(cur_ctx), 16'd1);
    enter(3'd5);
    chk("R8 full ignored", 16'(cur_ctx), 16'd1);
    leave();
    chk("R8 no extra push", 16'(cur_ctx), 16'd0);
    for (int k = 0; k < 6; k++) leave();
    enter(3'd5);
    chk("R7 balanced", 16'(cur_ctx), 16'd2);
    leave();
    chk("R7 final", 16'(cur_ctx), 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule